// File: doc/BRIEF.md
# Block Load/Store Address Sequencer

This unit walks a multi-register memory transfer one word at a time. A command carries a base address, a 16-bit set of selected registers, an addressing code, a load/store direction bit and a base-update bit. The unit turns that command into a stream of single-word requests. Each request carries a byte address, the index of the register it moves, and the direction. The memory and the register file sit outside the block.

Whatever addressing style is chosen, the block always visits the selected registers from the lowest index upward, at addresses that rise by one word per transfer. The addressing style only moves the first address and the final base value. The four direct styles are increment-after, increment-before, decrement-after and decrement-before. A stack-alias input reinterprets the addressing code as a stack discipline (full/empty, ascending/descending). The direction bit then picks the direct style that discipline implies.

Control is a three-state machine:
- IDLE accepts a command and moves to WALK, or straight to FINISH when the mask is empty.
- WALK issues one request per ready handshake and moves to FINISH after the last accepted transfer.
- FINISH presents `done` and the new base for one cycle, then returns to IDLE.

Top module: `mxfer_seq`

## Requirements
- R1: After reset `busy`, `req_valid`, `done` and `wb_en` are 0.
- R2: With `cmd_stack`=0, `cmd_code` selects the style: 00 increment-after (first address = base), 01 increment-before (base+4), 10 decrement-after (base−4n+4), 11 decrement-before (base−4n). Here n is the number of set mask bits, and arithmetic wraps modulo 2^32.
- R3: Successive accepted requests rise by 4 in address. Their register indices are the set mask bits taken lowest first, so the lowest register always gets the lowest address.
- R4: A request with `req_ready` low stays valid with unchanged address and register index. Exactly n requests are accepted per command.
- R5: With `cmd_stack`=1, `cmd_code` names a stack discipline and maps as follows. 00 full-descending: store→decrement-before, load→increment-after. 01 full-ascending: store→increment-before, load→decrement-after. 10 empty-descending: store→decrement-after, load→increment-before. 11 empty-ascending: store→increment-after, load→decrement-before.
- R6: While `done` is high, `wb_value` is base+4n for increment styles and base−4n for decrement styles. `wb_en` equals the command's `cmd_wb` bit during `done` and is 0 otherwise.
- R7: An empty mask produces no request. `done` rises in the cycle after acceptance, with `wb_value` equal to base.
- R8: A `cmd_valid` pulse while `busy` is high is ignored. The running transfer's addresses, indices and final `wb_value` are unchanged.
- R9: `req_load` equals the accepted command's `cmd_load` on every request.
- R10: `done` is high for exactly one cycle, after which `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, sampled in IDLE |
| cmd_base | input | 32 | Base byte address |
| cmd_mask | input | 16 | Selected-register set |
| cmd_code | input | 2 | Addressing style or stack discipline code |
| cmd_stack | input | 1 | 1: interpret `cmd_code` as a stack discipline |
| cmd_load | input | 1 | 1: load, 0: store |
| cmd_wb | input | 1 | Request base update |
| req_ready | input | 1 | Memory accepts the current request |
| busy | output | 1 | Command in progress (WALK or FINISH) |
| req_valid | output | 1 | Request present |
| req_addr | output | 32 | Request byte address |
| req_reg | output | 4 | Register index of the request |
| req_load | output | 1 | Request direction |
| done | output | 1 | Command complete (one cycle) |
| wb_en | output | 1 | Base update strobe |
| wb_value | output | 32 | Updated base |

## Verification
The bench targets several corner cases. It sends sparse masks with gaps, where a design that scanned from the top or walked the mask in written order would pair registers with the wrong addresses. It uses single-bit and full masks, where an off-by-one in the decrement start would be off by one word. Each stack alias is sent in both directions, where a swapped mapping shows up as a wrong first address. It also covers a base that wraps through zero. Stalls on `req_ready` catch a design that advances without a handshake. An empty mask catches one that issues a stray request. A command sent mid-transfer catches a design that re-latches its inputs while busy.

// File: rtl/mxfer_pkg.sv
package mxfer_pkg;
    typedef enum logic [1:0] {
        STY_INC_AFTER  = 2'b00,
        STY_INC_BEFORE = 2'b01,
        STY_DEC_AFTER  = 2'b10,
        STY_DEC_BEFORE = 2'b11
    } style_e;

    typedef enum logic [1:0] {
        STK_FULL_DESC  = 2'b00,
        STK_FULL_ASC   = 2'b01,
        STK_EMPTY_DESC = 2'b10,
        STK_EMPTY_ASC  = 2'b11
    } stack_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_WALK   = 2'b01,
        ST_FINISH = 2'b10
    } seq_state_e;
endpackage

// File: rtl/mxfer_style_map.sv
module mxfer_style_map
    import mxfer_pkg::*;
(
    input  logic       stack_en,
    input  logic [1:0] code,
    input  logic       is_load,
    output style_e     style
);
    always_comb begin
        if (!stack_en) begin
            style = style_e'(code);
        end else begin
            unique case (stack_e'(code))
                STK_FULL_DESC:  style = is_load ? STY_INC_AFTER  : STY_DEC_BEFORE;
                STK_FULL_ASC:   style = is_load ? STY_DEC_AFTER  : STY_INC_BEFORE;
                STK_EMPTY_DESC: style = is_load ? STY_INC_BEFORE : STY_DEC_AFTER;
                STK_EMPTY_ASC:  style = is_load ? STY_DEC_BEFORE : STY_INC_AFTER;
                default:        style = STY_INC_AFTER;
            endcase
        end
    end
endmodule

// File: rtl/mxfer_addr_plan.sv
module mxfer_addr_plan
    import mxfer_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [NREG-1:0]   mask,
    input  style_e            style,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] new_base
);
    localparam int CNT_W = $clog2(NREG + 1);

    logic [CNT_W-1:0]  n_sel;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] word;

    always_comb begin
        n_sel = '0;
        for (int i = 0; i < NREG; i++) begin
            n_sel = n_sel + CNT_W'(mask[i]);
        end
    end

    assign word = ADDR_W'(WORD_BYTES);
    assign span = ADDR_W'(n_sel) * word;

    always_comb begin
        unique case (style)
            STY_INC_AFTER:  begin first_addr = base;               new_base = base + span; end
            STY_INC_BEFORE: begin first_addr = base + word;        new_base = base + span; end
            STY_DEC_AFTER:  begin first_addr = base - span + word; new_base = base - span; end
            STY_DEC_BEFORE: begin first_addr = base - span;        new_base = base - span; end
            default:        begin first_addr = base;               new_base = base;        end
        endcase
    end
endmodule

// File: rtl/mxfer_low_pick.sv
module mxfer_low_pick #(
    parameter int NREG = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  bits,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (bits[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/mxfer_seq.sv
module mxfer_seq
    import mxfer_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [NREG-1:0]   cmd_mask,
    input  logic [1:0]        cmd_code,
    input  logic              cmd_stack,
    input  logic              cmd_load,
    input  logic              cmd_wb,
    input  logic              req_ready,
    output logic              busy,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [IDX_W-1:0]  req_reg,
    output logic              req_load,
    output logic              done,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_value
);
    seq_state_e        state_q, state_d;
    style_e            style;
    logic [ADDR_W-1:0] first_addr, new_base;
    logic [NREG-1:0]   remain_q;
    logic [ADDR_W-1:0] addr_q, wbv_q;
    logic              load_q, wbf_q;
    logic [IDX_W-1:0]  low_idx;
    logic              accept, step, last;

    mxfer_style_map u_map (
        .stack_en (cmd_stack),
        .code     (cmd_code),
        .is_load  (cmd_load),
        .style    (style)
    );

    mxfer_addr_plan #(.ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_plan (
        .base       (cmd_base),
        .mask       (cmd_mask),
        .style      (style),
        .first_addr (first_addr),
        .new_base   (new_base)
    );

    mxfer_low_pick #(.NREG(NREG)) u_pick (
        .bits (remain_q),
        .idx  (low_idx)
    );

    assign accept = (state_q == ST_IDLE) && cmd_valid;
    assign step   = (state_q == ST_WALK) && req_ready;
    assign last   = (remain_q & (remain_q - NREG'(1))) == '0;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_valid) state_d = (cmd_mask == '0) ? ST_FINISH : ST_WALK;
            ST_WALK:   if (req_ready && last) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Command context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            addr_q   <= '0;
            wbv_q    <= '0;
            load_q   <= 1'b0;
            wbf_q    <= 1'b0;
        end else if (accept) begin
            remain_q <= cmd_mask;
            addr_q   <= first_addr;
            wbv_q    <= new_base;
            load_q   <= cmd_load;
            wbf_q    <= cmd_wb;
        end else if (step) begin
            remain_q <= remain_q & (remain_q - NREG'(1));
            addr_q   <= addr_q + ADDR_W'(WORD_BYTES);
        end
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        req_valid = 1'b0;
        done      = 1'b0;
        wb_en     = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_WALK:   begin busy = 1'b1; req_valid = 1'b1; end
            ST_FINISH: begin busy = 1'b1; done = 1'b1; wb_en = wbf_q; end
            default:   ;
        endcase
    end

    assign req_addr = addr_q;
    assign req_reg  = low_idx;
    assign req_load = load_q;
    assign wb_value = wbv_q;

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_valid || req_addr == $past(req_addr) + ADDR_W'(WORD_BYTES)));
    // R3
    reg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_valid || req_reg > $past(req_reg)));
    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_reg)));
    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cmd_valid) |=> ($stable(wb_value) && $stable(req_load)));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    // R6
    wb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);
endmodule

// File: tb/tb_mxfer_seq.sv
module tb_mxfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_base = '0;
    logic [15:0] cmd_mask = '0;
    logic [1:0]  cmd_code = '0;
    logic        cmd_stack = 1'b0, cmd_load = 1'b0, cmd_wb = 1'b0;
    logic        req_ready = 1'b0;
    logic        busy, req_valid, req_load, done, wb_en;
    logic [31:0] req_addr, wb_value;
    logic [3:0]  req_reg;

    int n_chk = 0;
    int n_bad = 0;
    int stall_ctr = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mxfer_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_base(cmd_base),
        .cmd_mask(cmd_mask), .cmd_code(cmd_code), .cmd_stack(cmd_stack),
        .cmd_load(cmd_load), .cmd_wb(cmd_wb), .req_ready(req_ready),
        .busy(busy), .req_valid(req_valid), .req_addr(req_addr), .req_reg(req_reg),
        .req_load(req_load), .done(done), .wb_en(wb_en), .wb_value(wb_value)
    );

    typedef struct packed {
        logic [31:0] base;
        logic [15:0] mask;
        logic        stk;
        logic [1:0]  code;
        logic        ld;
        logic        wb;
        logic [31:0] start;
        logic [31:0] wbv;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{32'h1000, 16'h0007, 1'b0, 2'b00, 1'b0, 1'b1, 32'h1000, 32'h100C},
        '{32'h1000, 16'h8001, 1'b0, 2'b01, 1'b1, 1'b1, 32'h1004, 32'h1008},
        '{32'h2000, 16'h00F0, 1'b0, 2'b10, 1'b0, 1'b1, 32'h1FF4, 32'h1FF0},
        '{32'h2000, 16'h0C03, 1'b0, 2'b11, 1'b1, 1'b0, 32'h1FF0, 32'h1FF0},
        '{32'h3000, 16'h4003, 1'b1, 2'b00, 1'b0, 1'b1, 32'h2FF4, 32'h2FF4},
        '{32'h2FF4, 16'h4003, 1'b1, 2'b00, 1'b1, 1'b1, 32'h2FF4, 32'h3000},
        '{32'h0500, 16'h0001, 1'b1, 2'b01, 1'b0, 1'b1, 32'h0504, 32'h0504},
        '{32'h0504, 16'h0001, 1'b1, 2'b01, 1'b1, 1'b1, 32'h0504, 32'h0500},
        '{32'h0800, 16'h0006, 1'b1, 2'b10, 1'b0, 1'b1, 32'h07FC, 32'h07F8},
        '{32'h07F8, 16'h0006, 1'b1, 2'b10, 1'b1, 1'b1, 32'h07FC, 32'h0800},
        '{32'h0900, 16'hFFFF, 1'b1, 2'b11, 1'b0, 1'b1, 32'h0900, 32'h0940},
        '{32'h0940, 16'hFFFF, 1'b1, 2'b11, 1'b1, 1'b0, 32'h0900, 32'h0900},
        '{32'h0004, 16'h0003, 1'b0, 2'b11, 1'b0, 1'b1, 32'hFFFFFFFC, 32'hFFFFFFFC}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        cmd_base = v.base; cmd_mask = v.mask; cmd_stack = v.stk;
        cmd_code = v.code; cmd_load = v.ld; cmd_wb = v.wb; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Walk one command to completion from the first negedge after acceptance.
    task automatic walk(input vec_t v, input string tag, input bit stalls);
        logic [15:0] rem = v.mask;
        int k = 0;
        int guard = 0;
        bit stalled = 0;
        logic [31:0] st_addr = '0;
        int exp_reg;
        while (!done && guard < 200) begin
            guard++;
            if (req_valid) begin
                if (stalled) check(req_addr == st_addr, "R4", "stall address", req_addr, st_addr);
                stall_ctr++;
                req_ready = stalls ? ((stall_ctr % 3) != 2) : 1'b1;
                if (req_ready) begin
                    exp_reg = 0;
                    for (int b = 15; b >= 0; b--) if (rem[b]) exp_reg = b;
                    check(req_addr == v.start + 32'(4 * k), "R3", {tag, " address"},
                          req_addr, v.start + 32'(4 * k));
                    check(32'(req_reg) == 32'(exp_reg), "R3", {tag, " register"},
                          32'(req_reg), 32'(exp_reg));
                    check(req_load == v.ld, "R9", "direction", 32'(req_load), 32'(v.ld));
                    rem[exp_reg] = 1'b0;
                    k++;
                    stalled = 0;
                end else begin
                    stalled = 1;
                    st_addr = req_addr;
                end
            end else begin
                req_ready = 1'b0;
            end
            @(negedge clk);
        end
        req_ready = 1'b0;
        check(done == 1'b1, "R4", {tag, " completion"}, 32'(done), 32'd1);
        check(rem == 16'h0, "R4", {tag, " all registers sent"}, 32'(rem), 32'd0);
        check(wb_value == v.wbv, "R6", {tag, " new base"}, wb_value, v.wbv);
        check(wb_en == v.wb, "R6", {tag, " base update strobe"}, 32'(wb_en), 32'(v.wb));
        @(negedge clk);
        check(!done && !busy, "R10", {tag, " single done"}, {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        vec_t z;
        vec_t h;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !req_valid && !done && !wb_en, "R1", "reset outputs",
              {28'd0, busy, req_valid, done, wb_en}, 32'd0);
        rst_n = 1'b1;

        // R2 direct styles, R5 stack aliases
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i]);
            walk(VEC[i], VEC[i].stk ? "R5 stack" : "R2 direct", 1'b1);
        end

        // R7 empty mask
        z = '{32'h0000ABC0, 16'h0, 1'b0, 2'b11, 1'b0, 1'b1, 32'h0000ABC0, 32'h0000ABC0};
        issue(z);
        check(!req_valid, "R7", "no request on empty mask", 32'(req_valid), 32'd0);
        check(done, "R7", "done after empty mask", 32'(done), 32'd1);
        walk(z, "R7 empty", 1'b0);

        // R8 command during busy is ignored
        h = '{32'h0100, 16'h0003, 1'b0, 2'b00, 1'b0, 1'b1, 32'h0100, 32'h0108};
        issue(h);
        cmd_base = 32'hDEAD0000; cmd_mask = 16'hFFFF; cmd_code = 2'b11;
        cmd_load = 1'b1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(req_addr == 32'h0100, "R8", "address after ignored command", req_addr, 32'h0100);
        check(req_reg == 4'd0, "R8", "register after ignored command", 32'(req_reg), 32'd0);
        check(req_load == 1'b0, "R8", "direction after ignored command", 32'(req_load), 32'd0);
        walk(h, "R8 busy", 1'b0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule